// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is a bank of sixteen general-purpose pins controlled through a small word-wide register bus. Every whole-port access carries one 16-bit word in which bit n belongs to pin n. Software chooses, for each pin, whether it drives or receives (direction), whether its input is watched (input enable), and how it is sensed: high level, low level, rising edge, falling edge, or any edge. A per-pin function-select bit can also hand the pad over to a peripheral path.

Each pin's raw input passes through a two-flop synchronizer before the sense logic sees it. In level mode the pin's data bit follows the pin level, adjusted for polarity. In edge mode a qualifying edge sets the data bit, and the bit stays set until software clears it. Two interrupt request lines, A and B, each combine the data bits through their own mask. The data register and both masks can be written directly or through set, clear and toggle aliases. These aliases change only the pins whose write bit is 1, so drivers can share the bank without a read-modify-write.

Top module: `gpio_sense_bank`

## Requirements
- R1: After reset, every readable register (data, both masks, direction, input enable, polarity, edge, both-edge, function select) reads 0. irq_a, irq_b, pad_oe and pad_out are 0.
- R2: For pins with input enable 0, the data register can be changed three ways. A write at address 0 loads it. A write at address 1 sets the bits written as 1. A write at address 2 clears the bits written as 1. Bits written as 0 through addresses 1 and 2 are left unchanged.
- R3: A write at address 3 inverts the data bit of every pin whose write bit is 1 (for pins with input enable 0).
- R4: Mask A is loaded, set, cleared and toggled at addresses 4, 5, 6 and 7. Mask B is handled the same way at addresses 8, 9, 10 and 11. Direction, input enable, polarity, edge, both-edge and function select are loaded whole at addresses 12, 13, 14, 15, 16 and 17, and read back what was written.
- R5: A write at address 18 puts the pins written as 1 into input mode: direction cleared, input enable set. A write at address 19 puts them into output mode: input enable cleared, direction set. Other pins keep their settings. Both addresses read 0.
- R6: A pin change reaches the data register on the third rising clock edge after it, through a two-stage synchronizer. A pin with input enable 0 is ignored: its data bit keeps the value software gave it.
- R7: With input enable 1 and edge 0 (level mode), the data bit equals the synchronized pin level XOR polarity, so polarity 1 means active low. Software writes to the data register have no effect on such a pin.
- R8: With input enable 1 and edge 1, the data bit is set by a qualifying edge. Polarity 0 selects rising, polarity 1 selects falling, and both-edge 1 selects either edge regardless of polarity. The bit stays set until cleared. An edge detected in the same cycle as a clear write leaves the bit set.
- R9: irq_a is 1 exactly when some pin has both its data bit and its mask A bit at 1. irq_b is formed the same way from mask B. The two lines are independent.
- R10: Where function select is 0, pad_out is the data bit and pad_oe is the direction bit. Where it is 1, pad_out and pad_oe are taken from periph_out and periph_oe.
- R11: Reads at an alias address (1 to 3, 5 to 7, 9 to 11) return the register that alias belongs to. Addresses 20 to 31 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 16 | Write data, bit n for pin n |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Raw pin levels |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| periph_out | input | 16 | Peripheral output value for selected pins |
| periph_oe | input | 16 | Peripheral output enable for selected pins |
| irq_a | output | 1 | Interrupt request gated by mask A |
| irq_b | output | 1 | Interrupt request gated by mask B |

## Verification
The properties assume that the bus inputs are clean at each rising edge. They also assume that an alias write is judged only on pins that the sense logic is not driving, which is why the write-alias properties apply only while input enable is 0 everywhere. The bench keeps to both assumptions. It drives the bus and the pins only at falling edges. It turns input enable off before each configuration change. It waits five cycles after each pin change, so the synchronizer has settled before a clear and before a check. Only the deliberate race between an edge and a clear breaks this rule.

// File: rtl/gpio_sense_pkg.sv
`timescale 1ns/1ps
package gpio_sense_pkg;
  localparam int ADDR_W = 5;

  // Alias operation encoded in the low two address bits of groups 0..2
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_TGL = 2'd3} alias_op_e;

  localparam logic [ADDR_W-1:0] A_DATA  = 5'd0;
  localparam logic [ADDR_W-1:0] A_DSET  = 5'd1;
  localparam logic [ADDR_W-1:0] A_DCLR  = 5'd2;
  localparam logic [ADDR_W-1:0] A_DTGL  = 5'd3;
  localparam logic [ADDR_W-1:0] A_MA    = 5'd4;
  localparam logic [ADDR_W-1:0] A_MACLR = 5'd6;
  localparam logic [ADDR_W-1:0] A_MB    = 5'd8;
  localparam logic [ADDR_W-1:0] A_MBCLR = 5'd10;
  localparam logic [ADDR_W-1:0] A_DIR   = 5'd12;
  localparam logic [ADDR_W-1:0] A_INEN  = 5'd13;
  localparam logic [ADDR_W-1:0] A_POL   = 5'd14;
  localparam logic [ADDR_W-1:0] A_EDGE  = 5'd15;
  localparam logic [ADDR_W-1:0] A_BOTH  = 5'd16;
  localparam logic [ADDR_W-1:0] A_FUNC  = 5'd17;
  localparam logic [ADDR_W-1:0] A_MKIN  = 5'd18;
  localparam logic [ADDR_W-1:0] A_MKOUT = 5'd19;

  // New value of one register bit under an alias write
  function automatic logic alias_bit(input logic cur, input logic w, input alias_op_e op);
    case (op)
      OP_LOAD: alias_bit = w;
      OP_SET:  alias_bit = cur | w;
      OP_CLR:  alias_bit = cur & ~w;
      default: alias_bit = cur ^ w;
    endcase
  endfunction

  // Edge qualification: any edge, or one direction chosen by polarity
  function automatic logic edge_hit(input logic rise, input logic fall,
                                    input logic pol, input logic both);
    if (both) edge_hit = rise | fall;
    else      edge_hit = pol ? fall : rise;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_now,
  output logic [W-1:0] sync_prev
);
  localparam int LAST = STAGES;

  // Stages 0..STAGES-1 synchronize; stage STAGES holds the previous level
  logic [W-1:0] stg [LAST+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAST; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i <= LAST; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_now  = stg[LAST-1];
  assign sync_prev = stg[LAST];
endmodule

// File: rtl/gpio_sense.sv
`timescale 1ns/1ps
module gpio_sense
  import gpio_sense_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] lvl_now,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] inen,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  output logic [W-1:0] hw_set,
  output logic [W-1:0] hw_force,
  output logic [W-1:0] hw_level
);
  genvar p;
  generate
    for (p = 0; p < W; p++) begin : g_pin
      logic rise, fall;
      assign rise        = inen[p] &  lvl_now[p] & ~lvl_prev[p];
      assign fall        = inen[p] & ~lvl_now[p] &  lvl_prev[p];
      assign hw_set[p]   = edge_sel[p] & edge_hit(rise, fall, pol[p], both[p]);
      assign hw_force[p] = inen[p] & ~edge_sel[p];
      assign hw_level[p] = lvl_now[p] ^ pol[p];
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_sense_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      hw_set,
  input  logic [W-1:0]      hw_force,
  input  logic [W-1:0]      hw_level,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      maska_q,
  output logic [W-1:0]      maskb_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      inen_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      edge_q,
  output logic [W-1:0]      both_q,
  output logic [W-1:0]      func_q
);
  logic      alias_wr;
  logic [1:0] grp;
  alias_op_e op;
  logic      wr_data, wr_ma, wr_mb;

  assign alias_wr = bus_we && (bus_addr < A_DIR);
  assign grp      = bus_addr[3:2];
  assign op       = alias_op_e'(bus_addr[1:0]);
  assign wr_data  = alias_wr && (grp == 2'd0);
  assign wr_ma    = alias_wr && (grp == 2'd1);
  assign wr_mb    = alias_wr && (grp == 2'd2);

  logic [W-1:0] data_sw, data_nx, maska_nx, maskb_nx;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign data_sw[b]  = wr_data ? alias_bit(data_q[b], bus_wdata[b], op) : data_q[b];
      // level mode owns the bit; otherwise a sensed edge wins over software
      assign data_nx[b]  = hw_force[b] ? hw_level[b] : (data_sw[b] | hw_set[b]);
      assign maska_nx[b] = wr_ma ? alias_bit(maska_q[b], bus_wdata[b], op) : maska_q[b];
      assign maskb_nx[b] = wr_mb ? alias_bit(maskb_q[b], bus_wdata[b], op) : maskb_q[b];
    end
  endgenerate

  logic [W-1:0] dir_nx, inen_nx, pol_nx, edge_nx, both_nx, func_nx;

  always_comb begin
    dir_nx  = dir_q;
    inen_nx = inen_q;
    pol_nx  = pol_q;
    edge_nx = edge_q;
    both_nx = both_q;
    func_nx = func_q;
    if (bus_we) begin
      case (bus_addr)
        A_DIR:   dir_nx  = bus_wdata;
        A_INEN:  inen_nx = bus_wdata;
        A_POL:   pol_nx  = bus_wdata;
        A_EDGE:  edge_nx = bus_wdata;
        A_BOTH:  both_nx = bus_wdata;
        A_FUNC:  func_nx = bus_wdata;
        A_MKIN: begin
          dir_nx  = dir_q & ~bus_wdata;
          inen_nx = inen_q | bus_wdata;
        end
        A_MKOUT: begin
          inen_nx = inen_q & ~bus_wdata;
          dir_nx  = dir_q | bus_wdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      maska_q <= '0;
      maskb_q <= '0;
      dir_q   <= '0;
      inen_q  <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      both_q  <= '0;
      func_q  <= '0;
    end else begin
      data_q  <= data_nx;
      maska_q <= maska_nx;
      maskb_q <= maskb_nx;
      dir_q   <= dir_nx;
      inen_q  <= inen_nx;
      pol_q   <= pol_nx;
      edge_q  <= edge_nx;
      both_q  <= both_nx;
      func_q  <= func_nx;
    end
  end
endmodule

// File: rtl/gpio_sense_bank.sv
`timescale 1ns/1ps
module gpio_sense_bank
  import gpio_sense_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic [W-1:0]      periph_out,
  input  logic [W-1:0]      periph_oe,
  output logic              irq_a,
  output logic              irq_b
);
  logic [W-1:0] sync_now, sync_prev;
  logic [W-1:0] hw_set, hw_force, hw_level;
  logic [W-1:0] data_q, maska_q, maskb_q, dir_q, inen_q, pol_q, edge_q, both_q, func_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (pad_in),
    .sync_now  (sync_now),
    .sync_prev (sync_prev)
  );

  gpio_sense #(.W(W)) u_sense (
    .lvl_now  (sync_now),
    .lvl_prev (sync_prev),
    .inen     (inen_q),
    .edge_sel (edge_q),
    .pol      (pol_q),
    .both     (both_q),
    .hw_set   (hw_set),
    .hw_force (hw_force),
    .hw_level (hw_level)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_set    (hw_set),
    .hw_force  (hw_force),
    .hw_level  (hw_level),
    .data_q    (data_q),
    .maska_q   (maska_q),
    .maskb_q   (maskb_q),
    .dir_q     (dir_q),
    .inen_q    (inen_q),
    .pol_q     (pol_q),
    .edge_q    (edge_q),
    .both_q    (both_q),
    .func_q    (func_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_DIR) begin
      case (bus_addr[3:2])
        2'd0:    bus_rdata = data_q;
        2'd1:    bus_rdata = maska_q;
        2'd2:    bus_rdata = maskb_q;
        default: bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        A_DIR:   bus_rdata = dir_q;
        A_INEN:  bus_rdata = inen_q;
        A_POL:   bus_rdata = pol_q;
        A_EDGE:  bus_rdata = edge_q;
        A_BOTH:  bus_rdata = both_q;
        A_FUNC:  bus_rdata = func_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = (func_q & periph_out) | (~func_q & data_q);
  assign pad_oe  = (func_q & periph_oe)  | (~func_q & dir_q);
  assign irq_a   = |(data_q & maska_q);
  assign irq_b   = |(data_q & maskb_q);
endmodule

// File: rtl/gpio_sense_bank_chk.sv
`timescale 1ns/1ps
module gpio_sense_bank_chk
  import gpio_sense_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic              irq_a,
  input logic              irq_b,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      inen_q,
  input logic [W-1:0]      edge_q,
  input logic [W-1:0]      dir_q
);
  // R2: set alias forces written ones to 1
  p_data_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DSET && inen_q == '0)
      |=> ((data_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R2: clear alias forces written ones to 0
  p_data_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DCLR && inen_q == '0)
      |=> ((data_q & $past(bus_wdata)) == '0));

  // R3: toggle alias inverts exactly the written ones
  p_data_tgl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DTGL && inen_q == '0)
      |=> (data_q == ($past(data_q) ^ $past(bus_wdata))));

  // R5: input-mode command
  p_mkin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MKIN)
      |=> (((dir_q & $past(bus_wdata)) == '0) &&
           ((inen_q & $past(bus_wdata)) == $past(bus_wdata))));

  // R8: a latched edge bit survives any cycle without a data write
  p_edge_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr < A_MA)
      |=> (($past(data_q & edge_q & inen_q) & ~data_q) == '0));

  // R9: clearing every mask bit silences the line
  p_irqa_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MACLR && bus_wdata == '1) |=> !irq_a);

  p_irqb_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MBCLR && bus_wdata == '1) |=> !irq_b);
endmodule

bind gpio_sense_bank gpio_sense_bank_chk #(.W(W)) u_chk (.*);

// File: tb/gpio_sense_bank_tb.sv
`timescale 1ns/1ps
module gpio_sense_bank_tb;
  import gpio_sense_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [W-1:0]      bus_wdata = '0;
  logic [W-1:0]      bus_rdata;
  logic [W-1:0]      pad_in = '0;
  logic [W-1:0]      pad_out, pad_oe;
  logic [W-1:0]      periph_out = '0;
  logic [W-1:0]      periph_oe = '0;
  logic              irq_a, irq_b;

  int n_checks = 0;
  int n_errs   = 0;

  gpio_sense_bank #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [W-1:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int k);
    logic [31:0] t;
    t = ((k + 1) * 32'h2F1B) ^ (k << 7) ^ 32'h5A3C;
    return t[W-1:0];
  endfunction

  // Alias arithmetic from R2/R3/R4: 0 load, 1 set, 2 clear, 3 toggle
  function automatic logic [W-1:0] alias_model(input logic [W-1:0] m, input logic [W-1:0] v, input int op);
    case (op)
      0: return v;
      1: return m | v;
      2: return m & ~v;
      default: return m ^ v;
    endcase
  endfunction

  // Expected data after pins go from a to b, from R7/R8
  function automatic logic [W-1:0] exp_sense(input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [W-1:0] pol, input logic [W-1:0] edg, input logic [W-1:0] both);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case ({edg[i], both[i], pol[i]})
        3'b000, 3'b010: r[i] = b[i];
        3'b001, 3'b011: r[i] = ~b[i];
        3'b100:         r[i] = ~a[i] & b[i];
        3'b101:         r[i] = a[i] & ~b[i];
        default:        r[i] = a[i] != b[i];
      endcase
    end
    return r;
  endfunction

  task automatic run_sense(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [W-1:0] pol, input logic [W-1:0] edg, input logic [W-1:0] both);
    logic [W-1:0] v;
    wr(A_INEN, '0);
    wr(A_POL, pol); wr(A_EDGE, edg); wr(A_BOTH, both);
    pad_in = a;
    settle(5);
    wr(A_MKIN, '1);
    settle(2);
    wr(A_DCLR, '1);
    pad_in = b;
    settle(5);
    rd(A_DATA, v);
    chk(tag, v, exp_sense(a, b, pol, edg, both));
  endtask

  initial begin
    #(4 * 150000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] model [3];
    logic [W-1:0] saved [18];

    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1: reset state
    for (int a = 0; a < 20; a++) begin
      rd(ADDR_W'(a), v);
      chk("R1 reset read", v, '0);
    end
    chk("R1 irq_a", {15'b0, irq_a}, '0);
    chk("R1 irq_b", {15'b0, irq_b}, '0);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);

    // R2 R3 R4 R11: alias sweep over data, mask A, mask B
    for (int g = 0; g < 3; g++) model[g] = '0;
    for (int g = 0; g < 3; g++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 4; k++) begin
          logic [W-1:0] d;
          d = pat(g * 16 + op * 4 + k);
          model[g] = alias_model(model[g], d, op);
          wr(ADDR_W'(g * 4 + op), d);
          rd(ADDR_W'(g * 4), v);
          if (g == 0) chk(op == 3 ? "R3 data toggle" : "R2 data alias", v, model[g]);
          else        chk("R4 mask alias", v, model[g]);
          for (int al = 1; al < 4; al++) begin
            rd(ADDR_W'(g * 4 + al), v);
            chk("R11 alias readback", v, model[g]);
          end
        end
      end
    end

    // R4: whole-word configuration registers, input enable last
    wr(A_DIR, 16'h1357); wr(A_POL, 16'h2468); wr(A_EDGE, 16'h9ABC);
    wr(A_BOTH, 16'hDEF0); wr(A_FUNC, 16'h0FF0); wr(A_INEN, 16'hC3A5);
    rd(A_DIR, v);  chk("R4 dir", v, 16'h1357);
    rd(A_POL, v);  chk("R4 pol", v, 16'h2468);
    rd(A_EDGE, v); chk("R4 edge", v, 16'h9ABC);
    rd(A_BOTH, v); chk("R4 both", v, 16'hDEF0);
    rd(A_FUNC, v); chk("R4 func", v, 16'h0FF0);
    rd(A_INEN, v); chk("R4 inen", v, 16'hC3A5);

    // R5: mode commands
    wr(A_DIR, 16'hFF00); wr(A_INEN, 16'h0F0F);
    wr(A_MKIN, 16'h3C3C);
    rd(A_DIR, v);  chk("R5 mkin dir", v, 16'hC300);
    rd(A_INEN, v); chk("R5 mkin inen", v, 16'h3F3F);
    wr(A_MKOUT, 16'h0303);
    rd(A_DIR, v);  chk("R5 mkout dir", v, 16'hC303);
    rd(A_INEN, v); chk("R5 mkout inen", v, 16'h3C3C);
    rd(A_MKIN, v); chk("R5 mkin reads 0", v, '0);
    rd(A_MKOUT, v); chk("R5 mkout reads 0", v, '0);

    // R11: unused addresses
    wr(A_INEN, '0);
    for (int a = 0; a < 18; a++) rd(ADDR_W'(a), saved[a]);
    wr(5'd20, '1); wr(5'd31, '1); wr(5'd25, 16'h1234);
    for (int a = 0; a < 18; a++) begin
      rd(ADDR_W'(a), v);
      chk("R11 unused write ignored", v, saved[a]);
    end
    rd(5'd20, v); chk("R11 unused reads 0", v, '0);
    rd(5'd31, v); chk("R11 unused reads 0", v, '0);

    // R9: interrupt lines, one pin at a time
    wr(A_FUNC, '0); wr(A_EDGE, '0); wr(A_POL, '0); wr(A_BOTH, '0);
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] one;
      one = 16'(1 << i);
      wr(A_DATA, one);
      wr(A_MA, one);
      wr(A_MB, ~one);
      chk("R9 irq_a on", {15'b0, irq_a}, 16'd1);
      chk("R9 irq_b off", {15'b0, irq_b}, 16'd0);
      wr(5'd9, one);
      chk("R9 irq_b on", {15'b0, irq_b}, 16'd1);
      wr(A_MACLR, one);
      chk("R9 irq_a off", {15'b0, irq_a}, 16'd0);
      wr(A_DCLR, one);
      chk("R9 irq_b off after data clear", {15'b0, irq_b}, 16'd0);
    end
    wr(A_MACLR, '1); wr(A_MBCLR, '1);

    // R10: pad path
    wr(A_DIR, 16'h0F0F); wr(A_DATA, 16'h1234);
    #1;
    chk("R10 gpio pad_oe", pad_oe, 16'h0F0F);
    chk("R10 gpio pad_out", pad_out, 16'h1234);
    periph_out = 16'hAAAA; periph_oe = 16'h5555;
    wr(A_FUNC, 16'hFF00);
    #1;
    chk("R10 mixed pad_out", pad_out, 16'hAA34);
    chk("R10 mixed pad_oe", pad_oe, 16'h550F);
    wr(A_FUNC, '0);
    #1;
    chk("R10 returned pad_out", pad_out, 16'h1234);
    wr(A_DIR, '0);

    // R6: latency of a level change
    wr(A_INEN, '0); wr(A_EDGE, '0); wr(A_POL, '0); wr(A_BOTH, '0);
    pad_in = '0;
    wr(A_MKIN, '1);
    settle(4);
    rd(A_DATA, v); chk("R6 level start", v, '0);
    @(negedge clk);
    pad_in = 16'h1234;
    settle(2);
    rd(A_DATA, v); chk("R6 not yet after two edges", v, '0);
    settle(1);
    rd(A_DATA, v); chk("R6 arrives on third edge", v, 16'h1234);

    // R7: software write has no effect in level mode
    pad_in = '1;
    settle(5);
    wr(A_DCLR, '1);
    rd(A_DATA, v); chk("R7 clear ignored", v, '1);
    wr(A_DATA, '0);
    rd(A_DATA, v); chk("R7 load ignored", v, '1);

    // R6: input enable 0 ignores the pin
    wr(A_INEN, '0);
    wr(A_DATA, 16'h00F0);
    pad_in = '0; settle(5); pad_in = '1; settle(5);
    rd(A_DATA, v); chk("R6 ignored level mode", v, 16'h00F0);
    wr(A_EDGE, '1); wr(A_BOTH, '1);
    pad_in = '0; settle(5); pad_in = 16'hA5A5; settle(5);
    rd(A_DATA, v); chk("R6 ignored edge mode", v, 16'h00F0);

    // R7 R8: uniform modes
    for (int m = 0; m < 6; m++) begin
      logic [W-1:0] mp, me, mb;
      mp = (m == 1 || m == 3 || m == 5) ? '1 : '0;
      me = (m >= 2) ? '1 : '0;
      mb = (m >= 4) ? '1 : '0;
      for (int k = 0; k < 6; k++)
        run_sense(m < 2 ? "R7 uniform level" : "R8 uniform edge",
                  pat(k + 10 * m), pat(k + 10 * m + 3), mp, me, mb);
    end

    // R7 R8: every mode mixed across pins
    for (int k = 0; k < 8; k++)
      run_sense("R8 mixed modes", pat(2 * k + 40), pat(2 * k + 41),
                16'hAAAA, 16'hCCCC, 16'hF0F0);

    // R8: sticky latch and edge-versus-clear race
    wr(A_INEN, '0); wr(A_EDGE, '1); wr(A_POL, '0); wr(A_BOTH, '0);
    pad_in = '0;
    wr(A_MKIN, '1);
    settle(4);
    wr(A_DCLR, '1);
    pad_in = '1; settle(5); pad_in = '0; settle(5);
    rd(A_DATA, v); chk("R8 rising bit stays set", v, '1);

    wr(A_DCLR, '1);
    rd(A_DATA, v); chk("R8 cleared", v, '0);
    @(negedge clk);
    pad_in = '1;
    settle(2);
    bus_we = 1'b1; bus_addr = A_DCLR; bus_wdata = '1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_DATA, v); chk("R8 edge wins over same-cycle clear", v, '1);

    pad_in = '0; settle(5);
    wr(A_DCLR, '1);
    @(negedge clk);
    pad_in = '1;
    settle(3);
    bus_we = 1'b1; bus_addr = A_DCLR; bus_wdata = '1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_DATA, v); chk("R8 later clear removes bit", v, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule